// File: doc/BRIEF.md
# Windowed Verdict Smoothing Detector

This block turns a noisy stream of one-bit classifier verdicts into a steady runtime alarm. Each verdict marks one classification period as malicious (1) or benign (0). The block keeps the sixteen most recent verdicts in a shift window. Each window position carries a fixed integer weight, and newer positions weigh more. This gives a fixed-point stand-in for an exponentially weighted moving average.

Two weighted sums are kept. One adds the weights of the occupied positions that hold a malicious verdict. The other adds the weights of the occupied positions that hold a benign verdict. The alarm is raised when the malicious sum is strictly larger than the benign sum. The absolute difference between the two sums is also output as a confidence figure.

The window contents and the occupancy flags form one context word. An operating system can read this word, write it back and clear it when it switches processes. Both sums are registers that are rebuilt from the window on every update. Restoring the word therefore restores the whole detector state.

Top module: `ewma_vote_filter`

## Requirements
- R1: After reset the window is empty, both sums are zero, the difference is zero, the alarm is low and the context word reads zero.
- R2: A verdict pulse shifts the window toward lower positions and drops position 0, the oldest. The new verdict enters position 15. In the context word, verdict bit k sits at bit k and the occupancy flag of position k sits at bit 16+k.
- R3: The weight of position k is 256 + sum over i=1..floor(k/2) of 2^i. Positions 0 and 1 weigh 256, positions 2 and 3 weigh 258, and positions 14 and 15 weigh 510.
- R4: The malicious sum adds the weights of occupied positions holding 1. The benign sum adds the weights of occupied positions holding 0. Unoccupied positions add to neither sum.
- R5: The difference output equals the absolute value of the malicious sum minus the benign sum.
- R6: The alarm is high exactly when the malicious sum is strictly greater than the benign sum, so a tie gives 0.
- R7: The sums, the difference and the alarm change only in the cycle after a verdict, write or clear has been sampled. With no such event they hold their values.
- R8: A clear empties the window and zeroes both sums. It takes priority over a simultaneous write or verdict.
- R9: A write loads the context word from the write data, and the sums follow that word one cycle later. A write takes priority over a simultaneous verdict.
- R10: Neither sum, nor their total, ever exceeds 5084, the total weight of a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| verdict_vld | input | 1 | One-cycle pulse: a new verdict is present |
| verdict | input | 1 | 1 means malicious, 0 means benign |
| ctx_clr | input | 1 | Clear the detector state |
| ctx_wr | input | 1 | Load the context word from ctx_wdata |
| ctx_wdata | input | 32 | Context word to restore |
| ctx_rdata | output | 32 | Current context word (occupancy flags in the high half, verdicts in the low half) |
| mal_sum | output | 32 | Weighted sum of the malicious verdicts |
| ben_sum | output | 32 | Weighted sum of the benign verdicts |
| diff | output | 32 | Absolute difference of the two sums |
| alarm | output | 1 | Malicious sum exceeds the benign sum |

## Verification
The assertions check on every cycle that:
- neither sum exceeds the full-window weight;
- the sums hold when no event arrives;
- a clear empties the state, and a write lands in the context word;
- a verdict enters the newest position and marks it occupied.

Only the bench's scenarios can show that the weight of each position matches the formula and that the sums match the window contents. They also show that a tie keeps the alarm low and that the difference is correct in both directions of sign. To cover these, a bench model is compared against the design over random verdict, write and clear sequences.

// File: rtl/ewma_vote_filter.sv
module ewma_vote_filter #(
  parameter int N  = 16,
  parameter int SW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            verdict_vld,
  input  logic            verdict,
  input  logic            ctx_clr,
  input  logic            ctx_wr,
  input  logic [2*N-1:0]  ctx_wdata,
  output logic [2*N-1:0]  ctx_rdata,
  output logic [SW-1:0]   mal_sum,
  output logic [SW-1:0]   ben_sum,
  output logic [SW-1:0]   diff,
  output logic            alarm
);
  localparam int HALF = N / 2;

  function automatic logic [SW-1:0] wgt(input int k);
    return SW'((1 << HALF) + (1 << (k / 2 + 1)) - 2);
  endfunction

  function automatic logic [SW-1:0] full_weight();
    logic [SW-1:0] t;
    t = '0;
    for (int k = 0; k < N; k++) t = t + wgt(k);
    return t;
  endfunction

  localparam logic [SW-1:0] FULL = full_weight();

  logic [N-1:0]  bits_q, occ_q, bits_n, occ_n;
  logic [SW-1:0] ms_n, bs_n;
  logic          upd;

  assign upd = ctx_clr | ctx_wr | verdict_vld;

  always_comb begin
    bits_n = bits_q;
    occ_n  = occ_q;
    if (ctx_clr) begin
      bits_n = '0;
      occ_n  = '0;
    end else if (ctx_wr) begin
      bits_n = ctx_wdata[N-1:0];
      occ_n  = ctx_wdata[2*N-1:N];
    end else if (verdict_vld) begin
      bits_n = {verdict, bits_q[N-1:1]};
      occ_n  = {1'b1, occ_q[N-1:1]};
    end
  end

  always_comb begin
    ms_n = '0;
    bs_n = '0;
    for (int k = 0; k < N; k++) begin
      if (occ_n[k]) begin
        if (bits_n[k]) ms_n = ms_n + wgt(k);
        else           bs_n = bs_n + wgt(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      occ_q   <= '0;
      mal_sum <= '0;
      ben_sum <= '0;
    end else if (upd) begin
      bits_q  <= bits_n;
      occ_q   <= occ_n;
      mal_sum <= ms_n;
      ben_sum <= bs_n;
    end
  end

  assign ctx_rdata = {occ_q, bits_q};
  assign alarm     = mal_sum > ben_sum;
  assign diff      = alarm ? mal_sum - ben_sum : ben_sum - mal_sum;

  assert_sum_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mal_sum <= FULL) && (ben_sum <= FULL) && ((mal_sum + ben_sum) <= FULL));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(mal_sum) && $stable(ben_sum) && $stable(ctx_rdata));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clr |=> (ctx_rdata == '0) && (mal_sum == '0) && (ben_sum == '0) && !alarm);

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && !ctx_clr) |=> ctx_rdata == $past(ctx_wdata));

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && !ctx_wr && !ctx_clr) |=>
      ctx_rdata[2*N-1] && (ctx_rdata[N-1] == $past(verdict)));
endmodule

// File: tb/ewma_vote_filter_tb.sv
module ewma_vote_filter_tb;
  logic        clk = 0, rst_n = 0;
  logic        verdict_vld = 0, verdict = 0, ctx_clr = 0, ctx_wr = 0;
  logic [31:0] ctx_wdata = '0, ctx_rdata, mal_sum, ben_sum, diff;
  logic        alarm;
  int total = 0, bad = 0;
  logic [15:0] m_bits = '0, m_occ = '0;

  always #2.5 clk = ~clk;

  ewma_vote_filter u_dut (.clk, .rst_n, .verdict_vld, .verdict, .ctx_clr,
    .ctx_wr, .ctx_wdata, .ctx_rdata, .mal_sum, .ben_sum, .diff, .alarm);

  function automatic int weight(int k);
    int w = 256;
    for (int i = 1; i <= k / 2; i++) w += 2 ** i;
    return w;
  endfunction

  function automatic int exp_sum(logic [15:0] b, logic [15:0] o, logic want);
    int s = 0;
    for (int k = 0; k < 16; k++) if (o[k] && b[k] == want) s += weight(k);
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int ms = exp_sum(m_bits, m_occ, 1'b1);
    int bs = exp_sum(m_bits, m_occ, 1'b0);
    chk({tag, " R2 ctx"}, ctx_rdata, {m_occ, m_bits});
    chk({tag, " R4 mal"}, mal_sum, ms);
    chk({tag, " R4 ben"}, ben_sum, bs);
    chk({tag, " R5 diff"}, diff, ms > bs ? ms - bs : bs - ms);
    chk({tag, " R6 alarm"}, {31'b0, alarm}, {31'b0, ms > bs});
  endtask

  task automatic step(logic v, logic d, logic c, logic w, logic [31:0] wd);
    verdict_vld = v; verdict = d; ctx_clr = c; ctx_wr = w; ctx_wdata = wd;
    @(negedge clk);
    if (c) begin m_bits = '0; m_occ = '0; end
    else if (w) begin m_bits = wd[15:0]; m_occ = wd[31:16]; end
    else if (v) begin m_bits = {d, m_bits[15:1]}; m_occ = {1'b1, m_occ[15:1]}; end
    verdict_vld = 0; ctx_clr = 0; ctx_wr = 0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    chk("R1 mal zero", mal_sum, 0);
    rst_n = 1;
    @(negedge clk);
    step(1, 1, 0, 0, 0);
    chk("R3 newest weight 510", mal_sum, 510);
    step(1, 0, 0, 0, 0);
    chk("R6 tie alarm low", {31'b0, alarm}, 0);
    chk("R5 tie diff zero", diff, 0);
    check_all("tie");
    step(0, 0, 0, 0, 0);
    check_all("R7 idle hold");
    for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0);
    chk("R10 full window mal", mal_sum, 5084);
    chk("R3 full weight", mal_sum, exp_sum(16'hFFFF, 16'hFFFF, 1'b1));
    check_all("R2 full ones");
    step(0, 0, 0, 1, 32'h0001_0001);
    chk("R3 oldest weight 256", mal_sum, 256);
    check_all("R9 write");
    step(0, 0, 0, 1, 32'h0004_0000);
    chk("R3 pos2 weight 258", ben_sum, 258);
    step(1, 1, 0, 1, 32'hFFFF_0000);
    check_all("R9 write beats verdict");
    chk("R6 benign heavy alarm", {31'b0, alarm}, 0);
    step(1, 1, 1, 1, 32'hFFFF_FFFF);
    check_all("R8 clear priority");
    chk("R8 ctx zero", ctx_rdata, 0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 70)      step(1, 1'($urandom_range(0, 1)), 0, 0, 0);
      else if (r < 85) step(0, 0, 0, 0, 0);
      else if (r < 95) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, 1, $urandom);
      else             step(1'($urandom_range(0, 1)), 1, 1, 1'($urandom_range(0, 1)), $urandom);
      check_all("rand R7");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule